// File: doc/BRIEF.md
# DRAM Open-Row Command Sequencer

This block sits between a simple request source and a DRAM command/address bus. Each request names a bank group, a bank, a row and a column, and whether it is a read or a write, optionally with auto-precharge. The block keeps a table of which row, if any, is open in every bank. From that table it picks the command sequence for the request.

- If the requested row is already open, it issues only the column command.
- If the bank is closed, it issues an activate followed by the column command.
- If the bank holds a different row, it issues a precharge, then an activate, then the column command.

The command bus is registered and uses the active-low chip-select / activate-select encoding. Cycles that carry no command drive a deselect. The activate-to-column spacing and the precharge-to-activate spacing are fixed cycle counts set by parameters. Every column command is one fixed burst of eight transfers.

Top module: `dram_cmd_seq`

## Requirements
- R1: During and after reset, with no request pending, `req_ready` is 1, and `cmd_cs_n`, `cmd_act_n`, `cmd_ras_n`, `cmd_cas_n` and `cmd_we_n` are all 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the cycle in which that request's column command appears on the bus. In that cycle `req_ready` is 1 again.
- R3: A request to a closed bank produces an activate in the first cycle after acceptance. The activate drives `cmd_cs_n`=0 and `cmd_act_n`=0. `cmd_bg`/`cmd_ba` carry the bank and `cmd_addr` carries the row. `cmd_ras_n`, `cmd_cas_n` and `cmd_we_n` carry row bits 16, 15 and 14.
- R4: A request whose row is already open in its bank produces only the column command, in the first cycle after acceptance.
- R5: A request to a bank that holds a different row produces a precharge in the first cycle after acceptance. The precharge drives `cmd_cs_n`=0, `cmd_act_n`=1, RAS/CAS/WE = 0/1/0 and `cmd_addr[10]`=0 (single bank), addressed to that bank. It is followed by an activate and then the column command.
- R6: A read column command drives RAS/CAS/WE = 1/0/1 and a write drives 1/0/0, both with `cmd_act_n`=1. `cmd_addr[9:0]` holds the column, `cmd_addr[10]` holds the auto-precharge flag, and all higher address bits are 0.
- R7: A column command that follows an activate appears exactly `T_RCD` cycles after it.
- R8: An activate that follows a precharge appears exactly `T_RP` cycles after it.
- R9: A column command with auto-precharge leaves its bank closed. The next request to that bank gets an activate and no precharge.
- R10: Open-row state is kept per bank. Activity in one bank never changes the hit, miss or conflict outcome for another bank.
- R11: The pattern `cmd_act_n`=1 with RAS/CAS/WE = 0/1/1 is never driven. Every cycle without a command is a deselect with all five control lines at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ap | input | 1 | Close the row after this access |
| req_bg | input | BG_W | Bank group |
| req_ba | input | BA_W | Bank within group |
| req_row | input | ROW_W | Row |
| req_col | input | COL_W | Column |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_act_n | output | 1 | Activate select, active low |
| cmd_ras_n | output | 1 | RAS / row bit 16 during activate |
| cmd_cas_n | output | 1 | CAS / row bit 15 during activate |
| cmd_we_n | output | 1 | WE / row bit 14 during activate |
| cmd_bg | output | BG_W | Bank group of the command |
| cmd_ba | output | BA_W | Bank of the command |
| cmd_addr | output | ADDR_W | Row, or column plus flags |

## Verification
A corrupted open-row entry shows at the ports on the very next request to that bank. A stale valid bit yields a column command with no preceding activate, or an activate where a precharge was due. A wrong stored row turns a hit into a three-command conflict, or the reverse. Every request is therefore compared against an independent bank model, and the model's expected path fixes the exact cycle of each command. A miscounted delay shifts a command by at least one cycle, and a wrong pin encoding is visible in the same cycle the command is issued.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [2:0] {K_NONE, K_ACT, K_RD, K_WR, K_PRE} cmd_kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_ACT, ST_COL} seq_state_e;
endpackage

// File: rtl/dcs_bank_table.sv
module dcs_bank_table #(
  parameter int NB    = 16,
  parameter int ROW_W = 18
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [$clog2(NB)-1:0] lk_idx,
  output logic                  lk_vld,
  output logic [ROW_W-1:0]      lk_row,
  input  logic                  open_en,
  input  logic [$clog2(NB)-1:0] open_idx,
  input  logic [ROW_W-1:0]      open_row,
  input  logic                  close_en,
  input  logic [$clog2(NB)-1:0] close_idx
);
  logic [NB-1:0]    vld_q;
  logic [ROW_W-1:0] row_mem [NB];

  // row storage: no reset, single write port
  always_ff @(posedge clk) begin
    if (open_en) row_mem[open_idx] <= open_row;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      if (open_en)  vld_q[open_idx]  <= 1'b1;
      if (close_en) vld_q[close_idx] <= 1'b0;
    end
  end

  assign lk_vld = vld_q[lk_idx];
  assign lk_row = row_mem[lk_idx];
endmodule

// File: rtl/dcs_seq_ctrl.sv
module dcs_seq_ctrl
  import dcs_pkg::*;
#(
  parameter int BG_W  = 2,
  parameter int BA_W  = 2,
  parameter int ROW_W = 18,
  parameter int COL_W = 10,
  parameter int T_RCD = 4,
  parameter int T_RP  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic                 req_ap,
  input  logic [BG_W-1:0]      req_bg,
  input  logic [BA_W-1:0]      req_ba,
  input  logic [ROW_W-1:0]     req_row,
  input  logic [COL_W-1:0]     req_col,
  output logic [BG_W+BA_W-1:0] lk_idx,
  input  logic                 lk_vld,
  input  logic [ROW_W-1:0]     lk_row,
  output logic                 open_en,
  output logic                 close_en,
  output logic [BG_W+BA_W-1:0] bank_idx,
  output cmd_kind_e            issue_kind,
  output logic [BG_W-1:0]      issue_bg,
  output logic [BA_W-1:0]      issue_ba,
  output logic [ROW_W-1:0]     issue_row,
  output logic [COL_W-1:0]     issue_col,
  output logic                 issue_ap
);
  localparam int TMAX  = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int CNT_W = $clog2(TMAX + 1);

  seq_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_q, ap_q;
  logic [BG_W-1:0]  bg_q;
  logic [BA_W-1:0]  ba_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             accept, fire;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign lk_idx    = {req_bg, req_ba};
  assign fire      = (st_q != ST_IDLE) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      wr_q  <= 1'b0;
      ap_q  <= 1'b0;
      bg_q  <= '0;
      ba_q  <= '0;
      row_q <= '0;
      col_q <= '0;
    end else if (accept) begin
      wr_q  <= req_write;
      ap_q  <= req_ap;
      bg_q  <= req_bg;
      ba_q  <= req_ba;
      row_q <= req_row;
      col_q <= req_col;
      cnt_q <= '0;
      if (!lk_vld)                st_q <= ST_ACT;
      else if (lk_row == req_row) st_q <= ST_COL;
      else                        st_q <= ST_PRE;
    end else if (st_q != ST_IDLE) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        unique case (st_q)
          ST_PRE: begin
            st_q  <= ST_ACT;
            cnt_q <= CNT_W'(T_RP - 1);
          end
          ST_ACT: begin
            st_q  <= ST_COL;
            cnt_q <= CNT_W'(T_RCD - 1);
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    issue_kind = K_NONE;
    if (fire) begin
      unique case (st_q)
        ST_PRE:  issue_kind = K_PRE;
        ST_ACT:  issue_kind = K_ACT;
        ST_COL:  issue_kind = wr_q ? K_WR : K_RD;
        default: issue_kind = K_NONE;
      endcase
    end
  end

  assign issue_bg  = bg_q;
  assign issue_ba  = ba_q;
  assign issue_row = row_q;
  assign issue_col = col_q;
  assign issue_ap  = ap_q;
  assign bank_idx  = {bg_q, ba_q};
  assign open_en   = (issue_kind == K_ACT);
  assign close_en  = (issue_kind == K_PRE) ||
                     (ap_q && (issue_kind == K_RD || issue_kind == K_WR));
endmodule

// File: rtl/dcs_cmd_enc.sv
module dcs_cmd_enc
  import dcs_pkg::*;
#(
  parameter int BG_W   = 2,
  parameter int BA_W   = 2,
  parameter int ROW_W  = 18,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_kind_e         kind,
  input  logic [BG_W-1:0]   bg,
  input  logic [BA_W-1:0]   ba,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic              ap,
  output logic              cs_n,
  output logic              act_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BG_W-1:0]   bg_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int AP_BIT = 10;

  logic [ADDR_W-1:0] row_x, col_x;

  always_comb begin
    row_x = ADDR_W'(row);
    col_x = ADDR_W'(col);
    col_x[AP_BIT] = ap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {cs_n, act_n, ras_n, cas_n, we_n} <= 5'b11111;
      bg_o   <= '0;
      ba_o   <= '0;
      addr_o <= '0;
    end else begin
      bg_o <= bg;
      ba_o <= ba;
      unique case (kind)
        K_ACT: begin
          {cs_n, act_n} <= 2'b00;
          {ras_n, cas_n, we_n} <= row_x[16:14];
          addr_o <= row_x;
        end
        K_RD: begin
          {cs_n, act_n, ras_n, cas_n, we_n} <= 5'b01101;
          addr_o <= col_x;
        end
        K_WR: begin
          {cs_n, act_n, ras_n, cas_n, we_n} <= 5'b01100;
          addr_o <= col_x;
        end
        K_PRE: begin
          {cs_n, act_n, ras_n, cas_n, we_n} <= 5'b01010;
          addr_o <= '0;
        end
        default: begin
          {cs_n, act_n, ras_n, cas_n, we_n} <= 5'b11111;
          addr_o <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
  import dcs_pkg::*;
#(
  parameter int BG_W   = 2,
  parameter int BA_W   = 2,
  parameter int ROW_W  = 18,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 18,
  parameter int T_RCD  = 4,
  parameter int T_RP   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_ap,
  input  logic [BG_W-1:0]   req_bg,
  input  logic [BA_W-1:0]   req_ba,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              cmd_cs_n,
  output logic              cmd_act_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [BG_W-1:0]   cmd_bg,
  output logic [BA_W-1:0]   cmd_ba,
  output logic [ADDR_W-1:0] cmd_addr
);
  localparam int NB = 1 << (BG_W + BA_W);

  logic [BG_W+BA_W-1:0] lk_idx, bank_idx;
  logic                 lk_vld, open_en, close_en, issue_ap;
  logic [ROW_W-1:0]     lk_row, issue_row;
  logic [COL_W-1:0]     issue_col;
  logic [BG_W-1:0]      issue_bg;
  logic [BA_W-1:0]      issue_ba;
  cmd_kind_e            issue_kind;

  dcs_seq_ctrl #(
    .BG_W(BG_W), .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .T_RCD(T_RCD), .T_RP(T_RP)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_ap(req_ap), .req_bg(req_bg), .req_ba(req_ba),
    .req_row(req_row), .req_col(req_col),
    .lk_idx(lk_idx), .lk_vld(lk_vld), .lk_row(lk_row),
    .open_en(open_en), .close_en(close_en), .bank_idx(bank_idx),
    .issue_kind(issue_kind), .issue_bg(issue_bg), .issue_ba(issue_ba),
    .issue_row(issue_row), .issue_col(issue_col), .issue_ap(issue_ap)
  );

  dcs_bank_table #(.NB(NB), .ROW_W(ROW_W)) u_banks (
    .clk(clk), .rst(rst),
    .lk_idx(lk_idx), .lk_vld(lk_vld), .lk_row(lk_row),
    .open_en(open_en), .open_idx(bank_idx), .open_row(issue_row),
    .close_en(close_en), .close_idx(bank_idx)
  );

  dcs_cmd_enc #(
    .BG_W(BG_W), .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)
  ) u_enc (
    .clk(clk), .rst(rst),
    .kind(issue_kind), .bg(issue_bg), .ba(issue_ba),
    .row(issue_row), .col(issue_col), .ap(issue_ap),
    .cs_n(cmd_cs_n), .act_n(cmd_act_n), .ras_n(cmd_ras_n),
    .cas_n(cmd_cas_n), .we_n(cmd_we_n),
    .bg_o(cmd_bg), .ba_o(cmd_ba), .addr_o(cmd_addr)
  );
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
  parameter int ADDR_W = 18,
  parameter int T_RCD  = 4,
  parameter int T_RP   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              act_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr
);
  localparam logic [1:0] L_NONE = 2'd0, L_ACT = 2'd1, L_COL = 2'd2, L_PRE = 2'd3;

  logic        is_cmd, is_act, is_col, is_pre;
  logic [1:0]  last_q;
  logic [31:0] since_q;

  assign is_cmd = !cs_n;
  assign is_act = is_cmd && !act_n;
  assign is_col = is_cmd && act_n && ras_n && !cas_n;
  assign is_pre = is_cmd && act_n && !ras_n && cas_n && !we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q  <= L_NONE;
      since_q <= '0;
    end else if (is_cmd) begin
      last_q  <= is_act ? L_ACT : (is_col ? L_COL : (is_pre ? L_PRE : L_NONE));
      since_q <= 32'd1;
    end else if (since_q != 32'hFFFF_FFFF) begin
      since_q <= since_q + 32'd1;
    end
  end

  a_r11_no_legacy_act: assert property (@(posedge clk) disable iff (rst)
    (is_cmd && act_n) |-> !(!ras_n && cas_n && we_n));
  a_r11_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (act_n && ras_n && cas_n && we_n));
  a_r7_rcd_gap: assert property (@(posedge clk) disable iff (rst)
    (is_col && last_q == L_ACT) |-> (since_q == 32'(T_RCD)));
  a_r8_rp_gap: assert property (@(posedge clk) disable iff (rst)
    (is_act && last_q == L_PRE) |-> (since_q == 32'(T_RP)));
  a_r5_pre_then_act: assert property (@(posedge clk) disable iff (rst)
    (is_cmd && last_q == L_PRE) |-> is_act);
  a_r5_pre_single_bank: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> !addr[10]);
endmodule

bind dram_cmd_seq dcs_checker #(.ADDR_W(ADDR_W), .T_RCD(T_RCD), .T_RP(T_RP)) i_chk (
  .clk(clk), .rst(rst), .cs_n(cmd_cs_n), .act_n(cmd_act_n),
  .ras_n(cmd_ras_n), .cas_n(cmd_cas_n), .we_n(cmd_we_n), .addr(cmd_addr)
);

// File: tb/test_dram_cmd_seq.sv
module test_dram_cmd_seq;
  localparam int BG_W = 2, BA_W = 2, ROW_W = 18, COL_W = 10, ADDR_W = 18;
  localparam int T_RCD = 3, T_RP = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_ap = 1'b0;
  logic [BG_W-1:0] req_bg = '0;
  logic [BA_W-1:0] req_ba = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_ready, cmd_cs_n, cmd_act_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
  logic [BG_W-1:0] cmd_bg;
  logic [BA_W-1:0] cmd_ba;
  logic [ADDR_W-1:0] cmd_addr;

  always #10 clk = ~clk;

  dram_cmd_seq #(.BG_W(BG_W), .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W),
                 .ADDR_W(ADDR_W), .T_RCD(T_RCD), .T_RP(T_RP)) i_dram_cmd_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_ap(req_ap), .req_bg(req_bg), .req_ba(req_ba),
    .req_row(req_row), .req_col(req_col), .cmd_cs_n(cmd_cs_n),
    .cmd_act_n(cmd_act_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
    .cmd_we_n(cmd_we_n), .cmd_bg(cmd_bg), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  bit        mv [16];
  bit        mc [16];
  logic [17:0] mr [16];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // 0 deselect, 1 activate, 2 read, 3 write, 4 precharge, 5 other
  function automatic int decode();
    if (cmd_cs_n) return 0;
    if (!cmd_act_n) return 1;
    case ({cmd_ras_n, cmd_cas_n, cmd_we_n})
      3'b101:  return 2;
      3'b100:  return 3;
      3'b010:  return 4;
      default: return 5;
    endcase
  endfunction

  task automatic run_req(input bit wr, input bit ap, input int bank,
                         input logic [17:0] row, input logic [9:0] col);
    int path, exp_n, n;
    int kk[3], at[3], bk[3], ek[3], et[3];
    logic [17:0] ad[3];
    logic [2:0]  rcw[3];
    bit quiet_ok, ready_col;
    string ptag;
    if (mv[bank] && mr[bank] == row) path = 0;
    else if (mv[bank]) path = 2;
    else path = 1;
    ptag = (path == 0) ? "R4 R10" : (path == 2) ? "R5" : (mc[bank] ? "R9" : "R3");
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_ap = ap;
    req_bg = 2'(bank >> 2); req_ba = 2'(bank & 3);
    req_row = row; req_col = col;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2", "ready after accept", req_ready, 0);
    n = 0; quiet_ok = 1; ready_col = 0;
    for (int i = 1; i <= 40; i++) begin
      int k;
      @(negedge clk);
      k = decode();
      if (k == 0) begin
        if (!(cmd_act_n && cmd_ras_n && cmd_cas_n && cmd_we_n)) quiet_ok = 0;
      end else if (n < 3) begin
        kk[n] = k; at[n] = i; ad[n] = cmd_addr; bk[n] = {cmd_bg, cmd_ba};
        rcw[n] = {cmd_ras_n, cmd_cas_n, cmd_we_n};
        n++;
        if (k == 2 || k == 3) begin
          ready_col = req_ready;
          break;
        end
      end else begin
        n++;
        break;
      end
    end
    case (path)
      0: begin exp_n = 1; ek[0] = wr ? 3 : 2; et[0] = 1; end
      1: begin exp_n = 2; ek[0] = 1; et[0] = 1; ek[1] = wr ? 3 : 2; et[1] = 1 + T_RCD; end
      default: begin
        exp_n = 3; ek[0] = 4; et[0] = 1; ek[1] = 1; et[1] = 1 + T_RP;
        ek[2] = wr ? 3 : 2; et[2] = 1 + T_RP + T_RCD;
      end
    endcase
    chk(n == exp_n, ptag, "command count", n, exp_n);
    chk(quiet_ok, "R11", "idle cycles are clean deselects", quiet_ok, 1);
    chk(ready_col, "R2", "ready in column cycle", ready_col, 1);
    for (int j = 0; j < 3; j++) begin
      if (j < n && j < exp_n) begin
        string ttag;
        ttag = (ek[j] == 1 && j > 0) ? "R8" : (ek[j] >= 2 && ek[j] <= 3 && j > 0) ? "R7" : ptag;
        chk(kk[j] == ek[j], (ek[j] == 2 || ek[j] == 3) ? "R6" : ptag, "command kind", kk[j], ek[j]);
        chk(at[j] == et[j], ttag, "command cycle", at[j], et[j]);
        chk(bk[j] == bank, "R10", "command bank", bk[j], bank);
        if (ek[j] == 1) begin
          chk(ad[j] == row, "R3", "activate row", ad[j], row);
          chk(rcw[j] == row[16:14], "R3", "row bits on RAS/CAS/WE", rcw[j], row[16:14]);
        end else if (ek[j] == 4) begin
          chk(ad[j][10] == 1'b0, "R5", "precharge single bank flag", ad[j][10], 0);
        end else begin
          logic [17:0] ea;
          ea = 18'(col) | (ap ? 18'h400 : 18'h0);
          chk(ad[j] == ea, "R6", "column address", ad[j], ea);
        end
      end
    end
    mv[bank] = !ap; mc[bank] = ap; mr[bank] = row;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 16; b++) begin mv[b] = 0; mc[b] = 0; mr[b] = '0; end
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    chk({cmd_cs_n, cmd_act_n, cmd_ras_n, cmd_cas_n, cmd_we_n} == 5'b11111, "R1",
        "control in reset", {cmd_cs_n, cmd_act_n, cmd_ras_n, cmd_cas_n, cmd_we_n}, 5'h1f);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk({cmd_cs_n, cmd_act_n, cmd_ras_n, cmd_cas_n, cmd_we_n} == 5'b11111 && req_ready,
        "R1", "idle after reset", cmd_cs_n, 1);
    // closed banks
    for (int b = 0; b < 16; b++) run_req(b[0], 1'b0, b, 18'(b * 3 + 1), 10'(b));
    // hits everywhere
    for (int b = 0; b < 16; b++) run_req(!b[0], 1'b0, b, 18'(b * 3 + 1), 10'(b + 100));
    // conflicts
    for (int b = 0; b < 16; b++) run_req(b[1], 1'b0, b, 18'(b * 3 + 2), 10'h3ff);
    // auto-precharge hit then reopen same row
    for (int b = 0; b < 16; b++) begin
      run_req(1'b1, 1'b1, b, 18'(b * 3 + 2), 10'h155);
      run_req(1'b0, 1'b0, b, 18'(b * 3 + 2), 10'h2aa);
    end
    // high row bits on the shared control pins
    for (int p = 0; p < 8; p++) begin
      run_req(p[0], 1'b0, 5, {1'b1, 3'(p), 14'h0a5a}, 10'(p));
      run_req(1'b0, p[1], 5, {1'b0, 3'(7 - p), 14'h3fff}, 10'h000);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule